// File: doc/BRIEF.md
# Allocation Tag Store and Load Unit

This unit keeps 4-bit allocation tags in an external byte-wide tag RAM, two tags to a byte. Every 16-byte data granule owns one nibble. The byte that holds a granule's tag is the physical pointer shifted right by five. Pointer bit 4 chooses which half of that byte is used. The unit takes one command at a time on a command port: an opcode, a pointer, a source tag and a destination operand. It then runs the RAM accesses that the command needs.

There are four commands: a single-granule tag store, a paired-granule tag store, a tag load, and a block fill. The block fill writes a replicated tag pair over a whole aligned block. A store that changes only one nibble of a byte does a read-modify-write, so the neighbouring tag survives. A paired store at an even granule writes the whole byte in one access. Store pointers must be granule aligned. A misaligned store ends with a fault and writes nothing. `busy` and `done` frame every command, because a command takes several cycles.

Top module: `tag_store_unit`

## Requirements
- R1: The tag byte index is `cmdPtr >> 5`. Pointer bit 4 at 0 selects bits 3:0 of that byte, and at 1 it selects bits 7:4. The RAM has one cycle of read latency.
- R2: Opcode 0 (single store) writes `cmdTag` into the selected nibble and leaves the other nibble of the byte unchanged.
- R3: A store (opcode 0 or 1) whose pointer has any of bits 3:0 set reports `fault` with `done` and writes no RAM byte. Opcodes 2 and 3 never fault.
- R4: Opcode 1 (paired store) with pointer bit 4 clear writes the whole byte with `cmdTag` in both nibbles.
- R5: Opcode 1 with pointer bit 4 set writes `cmdTag` into bits 7:4 of byte N and bits 3:0 of byte N+1. It keeps the other nibble of each byte.
- R6: Opcode 2 (load) returns `cmdDst` with bits 59:56 replaced by the selected nibble. All other bits pass through unchanged.
- R7: Opcode 3 (fill) covers a block of 2^(k+2) bytes, where k is `cfgBlkLog`. It aligns the byte index down to the block and writes `{cmdTag,cmdTag}` into all 2^(k-3) tag bytes of the block. For k below 3 it writes exactly one byte. Bytes outside the block stay unchanged.
- R8: A command is taken when `cmdValid` is high and `busy` is low. `busy` is high from the cycle after acceptance until `done`. `done` is a one-cycle pulse, and `fault` is valid with it.
- R9: Two single stores issued back to back into the two nibbles of the same byte both persist.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdValid | input | 1 | Command request |
| cmdOp | input | 2 | 0 single store, 1 paired store, 2 load, 3 fill |
| cmdPtr | input | ADDR_W | Physical pointer |
| cmdTag | input | 4 | Source tag |
| cmdDst | input | DATA_W | Destination operand for loads |
| cfgBlkLog | input | K_W | Fill block exponent k |
| busy | output | 1 | Command in progress |
| done | output | 1 | Command complete pulse |
| fault | output | 1 | Alignment fault, valid with done |
| loadData | output | DATA_W | Load result |
| ramEn | output | 1 | Tag RAM access enable |
| ramWe | output | 1 | Tag RAM write enable |
| ramAddr | output | ADDR_W-5 | Tag RAM byte index |
| ramWdata | output | 8 | Tag RAM write data |
| ramRdata | input | 8 | Tag RAM read data, one cycle after a read |

## Verification
A read-modify-write of one nibble can fall in the same cycle window as the write of the other nibble of that byte by the previous command. This happens when a new store is accepted as soon as `busy` drops. The bench provokes it by issuing two single stores to the low and high nibbles of one byte with no gap between them. It judges the result by reading the byte from its RAM model and by loading each nibble back through the unit. Either tag being lost shows up as a mismatch.

// File: rtl/tag_store_pkg.sv
package tag_store_pkg;
  typedef enum logic [1:0] {
    OP_STORE1 = 2'd0,
    OP_STORE2 = 2'd1,
    OP_LOAD   = 2'd2,
    OP_FILL   = 2'd3
  } tagOpE;

  typedef struct packed {
    logic latch;
    logic advance;
    logic wrFull;
    logic capLoad;
  } tagStrobeT;
endpackage

// File: rtl/tag_store_dp.sv
module tag_store_dp
  import tag_store_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  parameter int TAG_LSB = 56,
  parameter int K_W     = 4,
  localparam int IDX_W  = ADDR_W - 5,
  localparam int CNT_W  = 1 << K_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  tagStrobeT         strb,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdPtr,
  input  logic [3:0]        cmdTag,
  input  logic [DATA_W-1:0] cmdDst,
  input  logic [K_W-1:0]    cfgBlkLog,
  input  logic [7:0]        ramRdata,
  output logic [IDX_W-1:0]  ramAddr,
  output logic [7:0]        ramWdata,
  output logic [DATA_W-1:0] loadData,
  output logic              fillLast
);
  logic [IDX_W-1:0]  addrR;
  logic              nibHiR;
  logic [3:0]        tagR;
  logic [DATA_W-1:0] dstR, loadR, loadNext;
  logic [CNT_W-1:0]  cntR, lastR, lastNext;
  logic [IDX_W-1:0]  startIdx;
  logic [CNT_W-1:0]  oneC;

  always_comb begin
    oneC = CNT_W'(1);
    if (cfgBlkLog < K_W'(3)) lastNext = '0;
    else lastNext = (oneC << (cfgBlkLog - K_W'(3))) - oneC;
    startIdx = cmdPtr[ADDR_W-1:5];
    if (cmdOp == OP_FILL) startIdx = startIdx & ~IDX_W'(lastNext);
  end

  always_comb begin
    loadNext = dstR;
    loadNext[TAG_LSB +: 4] = nibHiR ? ramRdata[7:4] : ramRdata[3:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      addrR  <= '0;
      nibHiR <= 1'b0;
      tagR   <= '0;
      dstR   <= '0;
      loadR  <= '0;
      cntR   <= '0;
      lastR  <= '0;
    end else begin
      if (strb.latch) begin
        addrR  <= startIdx;
        nibHiR <= cmdPtr[4];
        tagR   <= cmdTag;
        dstR   <= cmdDst;
        cntR   <= '0;
        lastR  <= lastNext;
      end else if (strb.advance) begin
        addrR  <= addrR + IDX_W'(1);
        nibHiR <= 1'b0;
        cntR   <= cntR + CNT_W'(1);
      end
      if (strb.capLoad) loadR <= loadNext;
    end
  end

  always_comb begin
    if (strb.wrFull)  ramWdata = {tagR, tagR};
    else if (nibHiR)  ramWdata = {tagR, ramRdata[3:0]};
    else              ramWdata = {ramRdata[7:4], tagR};
  end

  assign ramAddr  = addrR;
  assign loadData = loadR;
  assign fillLast = (cntR == lastR);

  AST_FULL_REPLICATED: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrFull |-> ramWdata[7:4] == ramWdata[3:0]) else $error("replication"); // R4
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (strb.advance && !strb.latch) |=> ramAddr == $past(ramAddr) + IDX_W'(1)) else $error("step"); // R5
endmodule

// File: rtl/tag_store_ctrl.sv
module tag_store_ctrl
  import tag_store_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [1:0] cmdOp,
  input  logic [4:0] ptrLow,
  input  logic       fillLast,
  output tagStrobeT  strb,
  output logic       ramEn,
  output logic       ramWe,
  output logic       busy,
  output logic       done,
  output logic       fault
);
  typedef enum logic [2:0] {S_IDLE, S_RD, S_MRG, S_WRF, S_FILL, S_FIN} stateE;
  stateE state, stateNext;
  logic  isLoadR, pendR, faultR;
  logic  accept, misAlign;

  assign accept   = cmdValid && (state == S_IDLE);
  assign misAlign = (ptrLow[3:0] != 4'd0) && (cmdOp == OP_STORE1 || cmdOp == OP_STORE2);

  always_comb begin
    stateNext = state;
    strb      = '0;
    ramEn     = 1'b0;
    ramWe     = 1'b0;
    case (state)
      S_IDLE: if (accept) begin
        strb.latch = 1'b1;
        if (misAlign) stateNext = S_FIN;
        else case (cmdOp)
          OP_STORE2: stateNext = ptrLow[4] ? S_RD : S_WRF;
          OP_FILL:   stateNext = S_FILL;
          default:   stateNext = S_RD;
        endcase
      end
      S_RD: begin
        ramEn     = 1'b1;
        stateNext = S_MRG;
      end
      S_MRG: begin
        if (isLoadR) begin
          strb.capLoad = 1'b1;
          stateNext    = S_FIN;
        end else begin
          ramEn = 1'b1;
          ramWe = 1'b1;
          if (pendR) begin
            strb.advance = 1'b1;
            stateNext    = S_RD;
          end else stateNext = S_FIN;
        end
      end
      S_WRF: begin
        ramEn       = 1'b1;
        ramWe       = 1'b1;
        strb.wrFull = 1'b1;
        stateNext   = S_FIN;
      end
      S_FILL: begin
        ramEn       = 1'b1;
        ramWe       = 1'b1;
        strb.wrFull = 1'b1;
        if (fillLast) stateNext = S_FIN;
        else strb.advance = 1'b1;
      end
      S_FIN:   stateNext = S_IDLE;
      default: stateNext = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= S_IDLE;
      isLoadR <= 1'b0;
      pendR   <= 1'b0;
      faultR  <= 1'b0;
    end else begin
      state <= stateNext;
      if (accept) begin
        isLoadR <= (cmdOp == OP_LOAD);
        pendR   <= (cmdOp == OP_STORE2) && ptrLow[4];
        faultR  <= misAlign;
      end else if (state == S_MRG) begin
        pendR <= 1'b0;
      end
    end
  end

  assign busy  = (state != S_IDLE);
  assign done  = (state == S_FIN);
  assign fault = done && faultR;

  AST_FAULT_NO_WRITE: assert property (@(posedge clk) disable iff (!rstN)
    fault |-> !$past(ramWe)) else $error("fault wrote"); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done) else $error("done width"); // R8
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !busy) |=> busy) else $error("busy"); // R8
  AST_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (!rstN)
    ramWe |-> ramEn) else $error("we without en"); // R1
endmodule

// File: rtl/tag_store_unit.sv
module tag_store_unit
  import tag_store_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 64,
  parameter int TAG_LSB = 56,
  parameter int K_W     = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdValid,
  input  logic [1:0]        cmdOp,
  input  logic [ADDR_W-1:0] cmdPtr,
  input  logic [3:0]        cmdTag,
  input  logic [DATA_W-1:0] cmdDst,
  input  logic [K_W-1:0]    cfgBlkLog,
  output logic              busy,
  output logic              done,
  output logic              fault,
  output logic [DATA_W-1:0] loadData,
  output logic              ramEn,
  output logic              ramWe,
  output logic [ADDR_W-6:0] ramAddr,
  output logic [7:0]        ramWdata,
  input  logic [7:0]        ramRdata
);
  tagStrobeT strb;
  logic      fillLast;

  tag_store_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp),
    .ptrLow(cmdPtr[4:0]), .fillLast(fillLast), .strb(strb),
    .ramEn(ramEn), .ramWe(ramWe), .busy(busy), .done(done), .fault(fault)
  );

  tag_store_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .TAG_LSB(TAG_LSB), .K_W(K_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .cmdOp(cmdOp), .cmdPtr(cmdPtr),
    .cmdTag(cmdTag), .cmdDst(cmdDst), .cfgBlkLog(cfgBlkLog), .ramRdata(ramRdata),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .loadData(loadData), .fillLast(fillLast)
  );
endmodule

// File: tb/tb_tag_store_unit.sv
module tb_tag_store_unit;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int IDX_W  = ADDR_W - 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdValid = 1'b0;
  logic [1:0] cmdOp = '0;
  logic [ADDR_W-1:0] cmdPtr = '0;
  logic [3:0] cmdTag = '0;
  logic [DATA_W-1:0] cmdDst = '0;
  logic [3:0] cfgBlkLog = '0;
  logic busy, done, fault, ramEn, ramWe;
  logic [DATA_W-1:0] loadData;
  logic [IDX_W-1:0] ramAddr;
  logic [7:0] ramWdata;
  logic [7:0] ramRdata = '0;
  logic [7:0] mem [0:(1<<IDX_W)-1];

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic fault;
    logic [DATA_W-1:0] data;
    bit isLoad;
    string req;
  } expT;
  expT expQ[$];

  always #5 clk = ~clk;

  tag_store_unit dut (
    .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdPtr(cmdPtr),
    .cmdTag(cmdTag), .cmdDst(cmdDst), .cfgBlkLog(cfgBlkLog), .busy(busy),
    .done(done), .fault(fault), .loadData(loadData), .ramEn(ramEn), .ramWe(ramWe),
    .ramAddr(ramAddr), .ramWdata(ramWdata), .ramRdata(ramRdata)
  );

  always @(posedge clk) begin
    if (ramEn && ramWe) mem[ramAddr] <= ramWdata;
    if (ramEn && !ramWe) ramRdata <= mem[ramAddr];
  end

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops expected results as done pulses
  always @(negedge clk) begin
    if (rstN && done) begin
      if (expQ.size() == 0) check(1'b0, "R8 unexpected done", 64'd1, 64'd0);
      else begin
        expT e;
        e = expQ.pop_front();
        check(fault === e.fault, {e.req, " fault"}, 64'(fault), 64'(e.fault));
        if (e.isLoad) check(loadData === e.data, {e.req, " load"}, loadData, e.data);
      end
    end
  end

  task automatic issue(input logic [1:0] op, input logic [ADDR_W-1:0] ptr, input logic [3:0] tag,
                       input logic [DATA_W-1:0] dst, input logic [3:0] k,
                       input logic expFault, input logic [DATA_W-1:0] expData, input string req);
    expT e;
    while (busy) @(negedge clk);
    cmdValid = 1'b1; cmdOp = op; cmdPtr = ptr; cmdTag = tag; cmdDst = dst; cfgBlkLog = k;
    e.fault = expFault; e.data = expData; e.isLoad = (op == 2'd2); e.req = req;
    expQ.push_back(e);
    @(negedge clk);
    cmdValid = 1'b0;
    check(busy === 1'b1, "R8 busy after accept", 64'(busy), 64'd1);
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (busy || expQ.size() != 0) @(negedge clk);
  endtask

  task automatic memCheck(input int idx, input logic [7:0] exp, input string req);
    check(mem[idx] === exp, req, 64'(mem[idx]), 64'(exp));
  endtask

  initial begin
    for (int i = 0; i < (1<<IDX_W); i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy === 1'b0 && done === 1'b0, "R8 reset idle", {busy, done}, 64'd0);

    // R2 single store into low nibble, high nibble preserved
    mem[2] = 8'hA0;
    issue(2'd0, 16'h0040, 4'h5, '0, 4'd0, 1'b0, '0, "R2");
    waitIdle();
    memCheck(2, 8'hA5, "R2 low nibble store");
    // R9 back-to-back stores to both nibbles of one byte
    mem[3] = 8'h00;
    issue(2'd0, 16'h0060, 4'h6, '0, 4'd0, 1'b0, '0, "R9");
    issue(2'd0, 16'h0070, 4'hE, '0, 4'd0, 1'b0, '0, "R9");
    waitIdle();
    memCheck(3, 8'hE6, "R9 both nibbles persist");
    issue(2'd0, 16'h0050, 4'h3, '0, 4'd0, 1'b0, '0, "R1");
    waitIdle();
    memCheck(2, 8'h35, "R1 high nibble by bit4");

    // R3 misaligned stores fault and write nothing
    issue(2'd0, 16'h0048, 4'hF, '0, 4'd0, 1'b1, '0, "R3");
    issue(2'd1, 16'h0061, 4'hF, '0, 4'd0, 1'b1, '0, "R3");
    waitIdle();
    memCheck(2, 8'h35, "R3 no write single");
    memCheck(3, 8'hE6, "R3 no write pair");

    // R4 aligned pair store
    mem[4] = 8'h12;
    issue(2'd1, 16'h0080, 4'h7, '0, 4'd0, 1'b0, '0, "R4");
    waitIdle();
    memCheck(4, 8'h77, "R4 full byte");

    // R5 odd pair store across bytes
    mem[5] = 8'h12; mem[6] = 8'h34;
    issue(2'd1, 16'h00B0, 4'h9, '0, 4'd0, 1'b0, '0, "R5");
    waitIdle();
    memCheck(5, 8'h92, "R5 first byte high");
    memCheck(6, 8'h39, "R5 second byte low");

    // R6 loads; misaligned load does not fault (R3)
    issue(2'd2, 16'h00B0, 4'h0, 64'hFFFF_FFFF_FFFF_FFFF, 4'd0, 1'b0, 64'hF9FF_FFFF_FFFF_FFFF, "R6");
    issue(2'd2, 16'h00C0, 4'h0, 64'h0123_4567_89AB_CDEF, 4'd0, 1'b0, 64'h0923_4567_89AB_CDEF, "R6");
    issue(2'd2, 16'h0047, 4'h0, 64'h0, 4'd0, 1'b0, 64'h0500_0000_0000_0000, "R3 load");
    issue(2'd2, 16'h0050, 4'h0, 64'h0, 4'd0, 1'b0, 64'h0300_0000_0000_0000, "R9 readback");
    issue(2'd2, 16'h0070, 4'h0, 64'h0, 4'd0, 1'b0, 64'h0E00_0000_0000_0000, "R9 readback");
    waitIdle();

    // R7 fill k=5: byte idx 9 aligns to 8, four bytes
    for (int i = 7; i <= 12; i++) mem[i] = 8'h5A;
    issue(2'd3, 16'h0123, 4'hC, '0, 4'd5, 1'b0, '0, "R7");
    waitIdle();
    memCheck(7, 8'h5A, "R7 below block");
    for (int i = 8; i <= 11; i++) memCheck(i, 8'hCC, "R7 block byte");
    memCheck(12, 8'h5A, "R7 above block");

    // R7 fill k=2: single byte
    mem[16] = 8'h00; mem[17] = 8'h11;
    issue(2'd3, 16'h0200, 4'h4, '0, 4'd2, 1'b0, '0, "R7");
    waitIdle();
    memCheck(16, 8'h44, "R7 small block");
    memCheck(17, 8'h11, "R7 small block neighbour");

    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      check(1'b0, "watchdog", 64'd0, 64'd1);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule